// File: doc/BRIEF.md
# Seven-State Counter with Terminal-Decode Reload

This block is a 4-bit binary up-counter. Its cycle is shortened by a decoder that watches for one terminal state. When the counter sits in that state and is enabled, the next clock edge loads a fixed preset in place of the increment. A build-time parameter picks one of two seven-state configurations.

- **Zero-based:** the preset is 0000 and the terminal state is 6, so the count runs 0 through 6.
- **Offset:** the preset is 1001 and the terminal state is 15, so the count runs 9 through 15.

The cycle therefore does not have to begin at zero. The decoded terminal condition is also brought out as a terminal-count flag, so a downstream stage can use it as a divide-by-seven tick.

An active-low clear forces the count to zero at once, without waiting for a clock edge. In the offset configuration the counter then climbs through every value from 0 up to 15 before it settles into the 9..15 loop. Counting only takes place while the enable input is high.

Top module: `mod7_reload_counter`

## Requirements
- R1: While clr_n is low, count reads 0000 with no clock edge needed; in both configurations tc then reads 0.
- R2: On a rising edge where en is 0 and clr_n is high, count keeps its value.
- R3: On a rising edge where en is 1 and tc is 0, count becomes its previous value plus one.
- R4: In the zero-based configuration (MODE = MODE_ZERO_BASE), tc is 1 exactly when count bits 2 and 1 are both set. Among the reachable values 0..6 this means count = 6.
- R5: In the zero-based configuration, a rising edge with en = 1 while count = 6 loads 0000, so the sequence is 0,1,2,3,4,5,6,0.
- R6: In the offset configuration (MODE = MODE_PRESET_NINE), tc is 1 exactly when count = 15.
- R7: In the offset configuration, a rising edge with en = 1 while count = 15 loads 1001 (9), so the loop is 9..15, seven states.
- R8: In the offset configuration, after a clear the count passes through 0..15 once in order before entering the 9..15 loop.
- R9: tc depends only on the present count. It stays asserted while en is low and the count rests on the terminal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous active-low clear to 0000 |
| en | input | 1 | Count enable; when low the value holds |
| count | output | 4 | Present counter value |
| tc | output | 1 | Terminal state decoded; the next enabled edge reloads |

## Verification
The count is registered, so each enabled edge shows its effect in that same clock period. The bench drives en a quarter period after a rising edge and samples half a period after it. The expected value for that sample therefore comes from the en level that was applied before that edge.

tc is pure decode of the registered count, so it is due in the same sample as the count it belongs to. A clear is driven mid-period and is expected at the very next sample, without waiting for an edge.

Both configurations run side by side from the same stimulus. This lets a single scoreboard entry hold the expected outputs of both.

// File: rtl/mod7_pkg.sv
package mod7_pkg;
    localparam int CNT_W = 4;

    typedef enum logic {
        MODE_ZERO_BASE   = 1'b0,
        MODE_PRESET_NINE = 1'b1
    } mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } ctr_state_t;
endpackage

// File: rtl/mod7_term_decode.sv
module mod7_term_decode
    import mod7_pkg::*;
#(
    parameter mode_e MODE = MODE_ZERO_BASE
) (
    input  logic [CNT_W-1:0] value,
    output logic             hit
);
    generate
        if (MODE == MODE_ZERO_BASE) begin : g_partial
            // Only 0..6 is reachable, so bits 2 and 1 together mark state 6.
            logic unused_bits;
            assign unused_bits = ^{value[3], value[0]};
            assign hit = value[2] & value[1];
        end else begin : g_full
            assign hit = &value;
        end
    endgenerate
endmodule

// File: rtl/mod7_core.sv
module mod7_core
    import mod7_pkg::*;
(
    input  logic             clk,
    input  logic             clr_n,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] value
);
    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (load) st_d.value = preset;
            else      st_d.value = st_q.value + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.value;

    p_hold_r2: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && !$past(en)) |-> (value == $past(value)));

    p_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(en) && !$past(load)) |-> (value == $past(value) + CNT_W'(1)));

    p_reload_r7: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(en) && $past(load)) |-> (value == $past(preset)));
endmodule

// File: rtl/mod7_reload_counter.sv
module mod7_reload_counter
    import mod7_pkg::*;
#(
    parameter mode_e MODE = MODE_ZERO_BASE
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             en,
    output logic [CNT_W-1:0] count,
    output logic             tc
);
    localparam logic [CNT_W-1:0] PRESET   = (MODE == MODE_ZERO_BASE) ? CNT_W'(0) : CNT_W'(9);
    localparam logic [CNT_W-1:0] TERMINAL = (MODE == MODE_ZERO_BASE) ? CNT_W'(6) : CNT_W'(15);

    logic hit_w;

    mod7_term_decode #(.MODE(MODE)) u_dec (
        .value (count),
        .hit   (hit_w)
    );

    mod7_core u_core (
        .clk    (clk),
        .clr_n  (clr_n),
        .en     (en),
        .load   (hit_w),
        .preset (PRESET),
        .value  (count)
    );

    assign tc = hit_w;

    always @(posedge clk) begin
        if (!clr_n) begin
            a_clear_r1: assert (count == '0 && !tc);
        end
    end

    p_tc_match_r4: assert property (@(posedge clk) disable iff (!clr_n)
        tc == (count == TERMINAL));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(en) && $past(count) == TERMINAL) |-> (count == PRESET));

    p_no_skip_r8: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(count) != count) |->
            (count == $past(count) + CNT_W'(1) || count == PRESET));

    p_tc_steady_r9: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && !$past(en) && $past(tc)) |-> tc);
endmodule

// File: tb/sim_mod7_reload_counter.sv
module sim_mod7_reload_counter;
    import mod7_pkg::*;

    logic clk = 1'b0;
    logic clr_n = 1'b0;
    logic en = 1'b0;
    logic [3:0] cnt_a, cnt_b;
    logic tc_a, tc_b;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mod7_reload_counter #(.MODE(MODE_ZERO_BASE)) u0 (
        .clk(clk), .clr_n(clr_n), .en(en), .count(cnt_a), .tc(tc_a));
    mod7_reload_counter #(.MODE(MODE_PRESET_NINE)) u1 (
        .clk(clk), .clr_n(clr_n), .en(en), .count(cnt_b), .tc(tc_b));

    typedef struct {
        logic [3:0] ca;
        logic       ta;
        logic [3:0] cb;
        logic       tb;
        string      tag;
    } exp_t;

    exp_t sb[$];

    logic [3:0] m_a = 4'd0;
    logic [3:0] m_b = 4'd0;
    bit en_cur = 1'b0;
    bit clr_cur = 1'b1;

    function automatic logic [3:0] adv_a(logic [3:0] c);
        return (c == 4'd6) ? 4'd0 : c + 4'd1;
    endfunction
    function automatic logic [3:0] adv_b(logic [3:0] c);
        return (c == 4'd15) ? 4'd9 : c + 4'd1;
    endfunction

    task automatic step(bit e, bit clr, string tag);
        exp_t it;
        @(posedge clk);
        if (!clr_cur && en_cur) begin
            m_a = adv_a(m_a);
            m_b = adv_b(m_b);
        end
        #5;
        clr_n = !clr;
        en = e;
        en_cur = e;
        clr_cur = clr;
        if (clr) begin
            m_a = 4'd0;
            m_b = 4'd0;
        end
        it.ca = m_a;
        it.ta = (m_a == 4'd6);
        it.cb = m_b;
        it.tb = (m_b == 4'd15);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(it.tag, cnt_a, it.ca, "zero-based count");
            check(it.tag, tc_a, it.ta, "zero-based tc");
            check(it.tag, cnt_b, it.cb, "offset count");
            check(it.tag, tc_b, it.tb, "offset tc");
        end
    end

    initial begin
        // R1: clear state
        step(0, 1, "R1");
        step(1, 0, "R1");
        // R3 / R8: count up from zero
        for (int i = 0; i < 4; i++) step(1, 0, "R3");
        // R2: hold with enable low
        for (int i = 0; i < 3; i++) step(0, 0, "R2");
        // R4 / R9: reach 6 in the zero-based counter and rest there
        step(1, 0, "R4");
        step(0, 0, "R4");
        step(0, 0, "R9");
        step(0, 0, "R9");
        // R5: wrap from 6 to 0
        step(1, 0, "R5");
        step(1, 0, "R5");
        // R8 / R6 / R7: offset counter climbs to 15 then loops 9..15
        for (int i = 0; i < 12; i++) step(1, 0, "R8");
        for (int i = 0; i < 16; i++) step(1, 0, "R7");
        step(0, 0, "R6");
        // R1: clear in mid-loop, then R8 climb again
        step(0, 1, "R1");
        step(1, 0, "R1");
        for (int i = 0; i < 20; i++) step(1, 0, "R8");
        step(0, 0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule